// File: doc/BRIEF.md
# Synthesizer Register Access Framer

This block carries out one register read or write at a time on a serially programmed frequency synthesizer, using a four-wire SPI link in mode 0. A requester presents an address, a direction flag, a width flag (32 or 64 bits) and write data. The block then drives one chip-select code for the whole exchange. It shifts out an instruction byte, followed by the data phase, and returns the captured read word together with a single-cycle completion pulse.

The instruction byte and the data words form one continuous frame. A 64-bit write places the upper word on the wire before the lower word and releases chip select only after the lower word. Reads are always 32 bits wide. The SPI half-period, counted in system clocks, and the encoded chip-select value are build-time parameters.

Top module: `dds_spi_framer`

## Requirements
- R1: After reset, `spi_cs` is 0 (no device selected), `spi_sclk` is low, and `busy` and `done` are low.
- R2: The first 8 bits of every frame form the instruction byte, sent MSB first. Bit 7 is 1 for a read and 0 for a write, and bits 6..0 carry `req_addr`.
- R3: A 32-bit write (`req_read`=0, `req_wide`=0) sends a 40-bit frame: the instruction byte, then `req_wdata[31:0]` MSB first.
- R4: A 64-bit write (`req_read`=0, `req_wide`=1) sends a 72-bit frame under one chip-select assertion: the instruction byte, then `req_wdata[63:32]`, then `req_wdata[31:0]`, each MSB first.
- R5: A read sends a 40-bit frame whatever `req_wide` holds, drives `spi_mosi` low for all 32 data bits, and presents on `rdata` the 32 bits sampled from `spi_miso`. The first sampled bit becomes bit 31.
- R6: For the whole frame, `spi_cs` holds the parameter `CS_SEL` and goes to 0 afterwards. Each request produces exactly one assertion and never shows any other value.
- R7: Mode 0 timing: `spi_sclk` is low whenever `spi_cs` is 0. `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is sampled on each rising edge.
- R8: Each SCLK half lasts `HALF_CYCLES` clocks. `done` is first seen (2N+3)·`HALF_CYCLES` clocks after the accepting edge, for a frame of N bits. Chip select has then been released for 2·`HALF_CYCLES` clocks, which is one full SCLK period.
- R9: A request is taken only while `busy` is low. A request held during a transfer does not change the frame on the wire and does not start a second frame.
- R10: `done` is high for exactly one clock and `busy` falls in that same clock. After a read, `rdata` is valid from that clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_read | input | 1 | 1 = register read, 0 = write |
| req_wide | input | 1 | 1 = 64-bit write (ignored on reads) |
| req_addr | input | 7 | Register address |
| req_wdata | input | 2*DATA_W | Write data; low word used for 32-bit writes |
| busy | output | 1 | Transfer in progress, including the deselect gap |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Word captured by the last read |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the synthesizer |
| spi_miso | input | 1 | Serial data from the synthesizer |
| spi_cs | output | 3 | Encoded chip select, 0 when idle |

## Verification
The bench builds the framer with `HALF_CYCLES`=2 and `CS_SEL`=5. A 72-bit frame then closes in about 300 clocks, so several dozen random transfers fit easily next to the directed cases. The value 5 is neither the idle code nor an all-ones pattern, so a wrong or flickering select code is visible on the pins. The short half-period keeps the exact done latency and the gap measurable to the clock, and it leaves enough room for a request held during a transfer to overlap many SCLK edges.

// File: rtl/dds_spi_pkg.sv
// Shared definitions for the synthesizer register framer.
// Assumes: instruction phase is always one byte wide.
package dds_spi_pkg;
    localparam int INSTR_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // no device selected, waiting for a request
        ST_LOW,    // SCLK low half, MOSI settled
        ST_HIGH,   // SCLK high half, MISO already sampled
        ST_TAIL,   // final low half, select still held
        ST_GAP     // select released, one full SCLK period
    } fr_state_e;
endpackage

// File: rtl/dds_spi_half_timer.sv
// Half-period timer: while run is high, raises tick once every HALF_CYCLES
// clocks. The count restarts from zero whenever run is low.
// Assumes: HALF_CYCLES >= 2.
module dds_spi_half_timer #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYCLES - 1));

    // Count clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (HALF_CYCLES > 1) begin : g_tick_chk
            // Two adjacent ticks would shorten an SCLK half.
            assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dds_spi_shifter.sv
// Frame shift engine: holds the outgoing frame left-aligned, counts the bits
// that remain and collects the incoming serial bits.
// Assumes: load, shift and sample are never high in the same clock.
module dds_spi_shifter #(
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 72,
    parameter int LEN_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [LEN_W-1:0]   load_len,
    input  logic               shift,
    input  logic               sample,
    input  logic               miso,
    output logic               mosi,
    output logic               last,
    output logic [DATA_W-1:0]  rx_word
);
    logic [FRAME_W-1:0] tx_q;
    logic [LEN_W-1:0]   rem_q;

    assign mosi = tx_q[FRAME_W-1];
    assign last = (rem_q == LEN_W'(1));

    // Outgoing frame: load on accept, advance one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_frame;
        end else if (shift) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    // Remaining bit count of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_len;
        end else if (shift) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    // Incoming bits, first sampled bit ends up in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (sample) begin
            rx_word <= {rx_word[DATA_W-2:0], miso};
        end
    end

    // The frame may never advance past its final bit.
    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (rem_q > LEN_W'(1)));
endmodule

// File: rtl/dds_spi_framer.sv
// Register access framer for a serially programmed synthesizer.
// Sends instruction byte plus data phase in SPI mode 0 under one encoded
// chip-select value, returns the read word with a one-clock done pulse.
// Assumes: HALF_CYCLES >= 2; CS_SEL is nonzero; reads are 32-bit only.
module dds_spi_framer
    import dds_spi_pkg::*;
#(
    parameter int         HALF_CYCLES = 4,
    parameter logic [2:0] CS_SEL      = 3'd4,
    parameter int         DATA_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_read,
    input  logic                req_wide,
    input  logic [6:0]          req_addr,
    input  logic [2*DATA_W-1:0] req_wdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [2:0]          spi_cs
);
    localparam int FRAME_W = INSTR_BITS + 2 * DATA_W;
    localparam int SHORT_W = INSTR_BITS + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    fr_state_e          state_q;
    logic               sclk_q;
    logic [2:0]         cs_q;
    logic               gap_half_q;
    logic               done_q;
    logic               rd_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               tick;
    logic               accept;
    logic               last;
    logic [DATA_W-1:0]  rx_word;
    logic [FRAME_W-1:0] ld_frame;
    logic [LEN_W-1:0]   ld_len;
    logic [7:0]         instr;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign rdata    = rdata_q;
    assign spi_sclk = sclk_q;
    assign spi_cs   = cs_q;

    // Build the left-aligned frame and its length from the request.
    always_comb begin
        instr = {req_read, req_addr};
        if (req_read) begin
            ld_frame = {instr, {(2*DATA_W){1'b0}}};
            ld_len   = LEN_W'(SHORT_W);
        end else if (req_wide) begin
            ld_frame = {instr, req_wdata};
            ld_len   = LEN_W'(FRAME_W);
        end else begin
            ld_frame = {instr, req_wdata[DATA_W-1:0], {DATA_W{1'b0}}};
            ld_len   = LEN_W'(SHORT_W);
        end
    end

    dds_spi_half_timer #(
        .HALF_CYCLES(HALF_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q != ST_IDLE),
        .tick (tick)
    );

    dds_spi_shifter #(
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W),
        .LEN_W  (LEN_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_frame(ld_frame),
        .load_len  (ld_len),
        .shift     ((state_q == ST_HIGH) && tick && !last),
        .sample    ((state_q == ST_LOW) && tick),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .last      (last),
        .rx_word   (rx_word)
    );

    // Transfer sequencer: select, clock edges, deselect gap and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sclk_q     <= 1'b0;
            cs_q       <= 3'd0;
            gap_half_q <= 1'b0;
            done_q     <= 1'b0;
            rd_q       <= 1'b0;
            rdata_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_LOW;
                        cs_q    <= CS_SEL;
                        rd_q    <= req_read;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        state_q <= ST_HIGH;
                        sclk_q  <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk_q  <= 1'b0;
                        state_q <= last ? ST_TAIL : ST_LOW;
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cs_q       <= 3'd0;
                        gap_half_q <= 1'b0;
                        state_q    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half_q) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            if (rd_q) begin
                                rdata_q <= rx_word;
                            end
                        end else begin
                            gap_half_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion is a single clock.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Completion comes only after the select has been released and busy fell.
    assert_done_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((spi_cs == 3'd0) && !busy));

    // Serial clock idles low outside a selected frame.
    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs == 3'd0) |-> !spi_sclk);

    // Output data holds through every high SCLK half.
    assert_mosi_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // A transfer starts only from a presented request.
    assert_start_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/dds_spi_framer_bench.sv
// Self-checking bench: directed corners plus seeded random transfers against
// a behavioural SPI target that records the frame and serves read data.
module dds_spi_framer_bench;
    localparam int         HALF   = 2;
    localparam logic [2:0] CSV    = 3'd5;
    localparam int         DW     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_read = 1'b0;
    logic          req_wide = 1'b0;
    logic [6:0]    req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          busy, done, spi_sclk, spi_mosi, spi_miso;
    logic [31:0]   rdata;
    logic [2:0]    spi_cs;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    dds_spi_framer #(
        .HALF_CYCLES(HALF),
        .CS_SEL     (CSV),
        .DATA_W     (DW)
    ) u_dds_spi_framer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
    );

    // Behavioural target: frame capture and pin-level monitors.
    logic [71:0] frame = '0;
    logic [7:0]  nbits = '0;
    logic        prev_sclk = 1'b0;
    logic [2:0]  prev_cs = 3'd0;
    int          cs_asserts = 0;
    int          bad_cs = 0;
    int          sclk_nocs = 0;
    logic [31:0] slave_word = '0;
    logic        slave_rd = 1'b0;

    always @(posedge clk) begin
        prev_sclk <= spi_sclk;
        prev_cs   <= spi_cs;
        if (spi_cs != 3'd0 && spi_cs != CSV) bad_cs <= bad_cs + 1;
        if (spi_cs == 3'd0 && spi_sclk) sclk_nocs <= sclk_nocs + 1;
        if (prev_cs == 3'd0 && spi_cs != 3'd0) begin
            cs_asserts <= cs_asserts + 1;
            frame <= '0;
            nbits <= '0;
        end else if (spi_sclk && !prev_sclk && spi_cs != 3'd0) begin
            frame <= {frame[70:0], spi_mosi};
            nbits <= nbits + 8'd1;
        end
    end

    always_comb begin
        int idx;
        idx = 39 - int'(nbits);
        if (slave_rd && nbits >= 8'd8 && nbits < 8'd40) spi_miso = slave_word[idx];
        else spi_miso = 1'b0;
    end

    task automatic check(input bit ok, input string req, input logic [71:0] act,
                         input logic [71:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] exp_frame(input logic rd, input logic wide,
                                              input logic [6:0] addr, input logic [63:0] wd);
        if (rd) return {32'd0, 1'b1, addr, 32'd0};
        if (wide) return {1'b0, addr, wd[63:32], wd[31:0]};
        return {32'd0, 1'b0, addr, wd[31:0]};
    endfunction

    // One transfer; optionally keeps a junk request asserted while busy.
    task automatic xfer(input logic rd, input logic wide, input logic [6:0] addr,
                        input logic [63:0] wd, input logic [31:0] sword, input int junk);
        int nb;
        int c;
        int a0;
        int bc0;
        int sc0;
        logic [71:0] ef;
        logic [31:0] old_rdata;
        nb = (rd || !wide) ? 40 : 72;
        ef = exp_frame(rd, wide, addr, wd);
        old_rdata = rdata;
        a0 = cs_asserts; bc0 = bad_cs; sc0 = sclk_nocs;
        @(negedge clk);
        slave_word = sword;
        slave_rd = rd;
        req_valid = 1'b1; req_read = rd; req_wide = wide; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        c = 1;
        check(busy === 1'b1, "R9 busy after accept", 72'(busy), 72'd1);
        if (junk > 0) begin
            req_read = ~rd; req_wide = ~wide; req_addr = ~addr; req_wdata = ~wd;
        end else begin
            req_valid = 1'b0;
        end
        while (!done && c < 2000) begin
            @(negedge clk);
            c++;
            if (c == junk) req_valid = 1'b0;
        end
        check(c == (2*nb + 3)*HALF + 1, "R8 done latency", 72'(c), 72'((2*nb + 3)*HALF + 1));
        check(busy === 1'b0 && spi_cs === 3'd0, "R10 busy falls with done",
              {busy, spi_cs}, 72'd0);
        check(nbits == 8'(nb), "R3 R4 R5 frame bit count", 72'(nbits), 72'(nb));
        check(frame[7+nb-8 -: 8] == ef[nb-1 -: 8], "R2 instruction byte",
              72'(frame[nb-1 -: 8]), 72'(ef[nb-1 -: 8]));
        if (rd) begin
            check(frame[39:0] == ef[39:0], "R5 read frame zero data", frame, ef);
            check(rdata == sword, "R5 read data", 72'(rdata), 72'(sword));
        end else if (wide) begin
            check(frame == ef, "R4 wide write frame", frame, ef);
            check(rdata == old_rdata, "R10 rdata held on write", 72'(rdata), 72'(old_rdata));
        end else begin
            check(frame[39:0] == ef[39:0], "R3 narrow write frame", frame, ef);
        end
        check(cs_asserts == a0 + 1 && bad_cs == bc0, "R6 single select with code",
              72'(cs_asserts - a0), 72'd1);
        check(sclk_nocs == sc0, "R7 sclk idle when deselected", 72'(sclk_nocs - sc0), 72'd0);
        @(negedge clk);
        check(done === 1'b0, "R10 done one clock", 72'(done), 72'd0);
        check(cs_asserts == a0 + 1, "R9 no second frame", 72'(cs_asserts - a0), 72'd1);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(spi_cs === 3'd0 && spi_sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
              "R1 reset outputs", {spi_cs, spi_sclk, busy, done}, 72'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(spi_cs === 3'd0 && busy === 1'b0, "R1 idle after reset", {spi_cs, busy}, 72'd0);

        xfer(1'b0, 1'b0, 7'h7F, 64'h0123_4567_FFFF_FFFF, 32'h0, 0);          // R3
        xfer(1'b1, 1'b1, 7'h00, 64'h0, 32'hA5A5_0F0F, 0);                    // R5 wide ignored
        xfer(1'b0, 1'b1, 7'h0E, 64'h8000_0001_7FFF_FFFE, 32'h0, 0);          // R4
        xfer(1'b1, 1'b0, 7'h03, 64'h0, 32'hFFFF_FFFF, 0);                    // R5 all ones
        xfer(1'b1, 1'b0, 7'h55, 64'h0, 32'h8000_0001, 40);                   // R9 held request
        xfer(1'b0, 1'b1, 7'h2A, 64'hDEAD_BEEF_CAFE_F00D, 32'h0, 60);         // R9 during wide
        for (int i = 0; i < 30; i++) begin
            logic rd;
            logic wd_sel;
            rd = 1'($urandom);
            wd_sel = 1'($urandom);
            xfer(rd, wd_sel, 7'($urandom), {$urandom, $urandom}, $urandom,
                 ((i % 5) == 0) ? 30 : 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule